// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block sits beside a shared, word-addressed memory port used by several requesters and enforces atomic read-modify-write sequences. A requester opens a sequence with a linked load. The block then holds a reservation for that requester: one valid flag and the word address. A later conditional store from the same requester is allowed to write memory only if that reservation is still intact. The block drives the per-requester write enable for the memory and returns a one-bit pass/fail flag. The pipeline writes this flag into the destination register instead of store data.

Any write that lands on a reserved word breaks the reservation, whichever requester issues it. An ordinary store counts, and so does a successful conditional store. A conditional store always consumes the issuing requester's reservation. When several conditional stores target the same word in one cycle, the lowest requester index wins.

Each requester's lane is a valid-qualified request. The block applies no back-pressure: every request with its valid bit high is accepted in that cycle. The write enable and pass/fail flag are combinational in that same cycle, and reservation changes take effect from the next cycle.

Top module: `llsc_monitor`

## Requirements
- R1: A conditional store from requester i passes (sc_flag[i]=1, mem_we[i]=1) when requester i holds a valid reservation on exactly that word address, no lower-indexed requester passes a conditional store to that word in the same cycle, and no other requester issues an ordinary store to that word in the same cycle.
- R2: A conditional store that does not pass gives sc_flag[i]=0 and mem_we[i]=0. For every accepted conditional store, sc_done[i]=1 in that cycle. sc_done and sc_flag are 0 for every other request.
- R3: Request codes on req_op, two bits per requester: 0 plain load, 1 linked load, 2 ordinary store, 3 conditional store. An accepted ordinary store always raises mem_we. Loads of either kind never raise mem_we, and plain loads leave every reservation unchanged.
- R4: A linked load sets the requester's reservation to its address and replaces any earlier reservation of that requester.
- R5: Any memory write to a reserved word clears that reservation, including the holder's own ordinary store and a passing conditional store from another requester.
- R6: A conditional store clears the issuing requester's reservation whether it passes or fails, including when its address differs from the reserved one.
- R7: When two or more conditional stores with valid reservations target the same word in one cycle, only the lowest-indexed one passes.
- R8: Reset clears all reservations, so a conditional store issued after reset fails until a new linked load is made.
- R9: Outputs are combinational in the request cycle. Reservation updates take effect at the next clock edge. A linked load in the same cycle as another requester's write to that word keeps the new reservation. A request with its valid bit low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Per-requester request valid |
| req_op | input | 2*N_REQ | Per-requester request code, requester i in bits [2i+1:2i] |
| req_addr | input | AW*N_REQ | Per-requester word address, requester i in bits [AW*i+AW-1:AW*i] |
| mem_we | output | N_REQ | Per-requester memory write enable |
| sc_done | output | N_REQ | Conditional-store result valid this cycle |
| sc_flag | output | N_REQ | Conditional-store pass (1) / fail (0) |

## Verification
A reservation that is wrongly kept or wrongly lost stays hidden until the holder issues its next conditional store. At that point it appears as a wrong sc_flag and a wrong mem_we in the same cycle, so every check that probes a reservation ends in a conditional store. A broken same-cycle arbitration shows at once as two write enables for one word. A stale reservation after a clearing write shows on the first conditional store that follows. The vectors place each clearing event immediately before that store so that an error cannot be masked by later traffic.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LINK  = 2'd1,
    OP_STORE = 2'd2,
    OP_COND  = 2'd3
  } mem_op_e;
endpackage

// File: rtl/llsc_resv_slot.sv
// One reservation: valid flag plus reserved word address.
module llsc_resv_slot #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          drop_en,
  input  logic [AW-1:0] set_addr,
  output logic          held,
  output logic [AW-1:0] held_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_addr <= '0;
    end else if (set_en) begin
      held      <= 1'b1;
      held_addr <= set_addr;
    end else if (drop_en) begin
      held      <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_cond_arb.sv
// Fixed-priority resolution of same-cycle conditional stores.
module llsc_cond_arb #(
  parameter int N_REQ = 4,
  parameter int AW    = 16
) (
  input  logic [N_REQ-1:0]    cand,
  input  logic [N_REQ-1:0]    plain_st,
  input  logic [AW*N_REQ-1:0] addr_flat,
  output logic [N_REQ-1:0]    win
);
  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      win[i] = cand[i];
      for (int j = 0; j < N_REQ; j++) begin
        if (j != i && addr_flat[AW*j +: AW] == addr_flat[AW*i +: AW]) begin
          if (plain_st[j]) win[i] = 1'b0;
          if (j < i && cand[j]) win[i] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int AW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_REQ-1:0]    req_valid,
  input  logic [2*N_REQ-1:0]  req_op,
  input  logic [AW*N_REQ-1:0] req_addr,
  output logic [N_REQ-1:0]    mem_we,
  output logic [N_REQ-1:0]    sc_done,
  output logic [N_REQ-1:0]    sc_flag
);
  logic [N_REQ-1:0]    is_link, is_store, is_cond;
  logic [N_REQ-1:0]    held, cand, win, drop;
  logic [AW*N_REQ-1:0] held_addr;

  for (genvar g = 0; g < N_REQ; g++) begin : g_lane
    mem_op_e op;
    assign op          = mem_op_e'(req_op[2*g +: 2]);
    assign is_link[g]  = req_valid[g] && op == OP_LINK;
    assign is_store[g] = req_valid[g] && op == OP_STORE;
    assign is_cond[g]  = req_valid[g] && op == OP_COND;
    assign cand[g]     = is_cond[g] && held[g] &&
                         held_addr[AW*g +: AW] == req_addr[AW*g +: AW];

    llsc_resv_slot #(.AW(AW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (is_link[g]),
      .drop_en   (drop[g]),
      .set_addr  (req_addr[AW*g +: AW]),
      .held      (held[g]),
      .held_addr (held_addr[AW*g +: AW])
    );
  end

  llsc_cond_arb #(.N_REQ(N_REQ), .AW(AW)) u_arb (
    .cand      (cand),
    .plain_st  (is_store),
    .addr_flat (req_addr),
    .win       (win)
  );

  assign mem_we  = is_store | win;
  assign sc_done = is_cond;
  assign sc_flag = win;

  // A reservation is dropped by its own conditional store or by any write
  // landing on the reserved word this cycle.
  always_comb begin
    for (int k = 0; k < N_REQ; k++) begin
      drop[k] = is_cond[k];
      for (int j = 0; j < N_REQ; j++) begin
        if (mem_we[j] && req_addr[AW*j +: AW] == held_addr[AW*k +: AW])
          drop[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int N_REQ = 4,
  parameter int AW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_REQ-1:0]    req_valid,
  input logic [2*N_REQ-1:0]  req_op,
  input logic [AW*N_REQ-1:0] req_addr,
  input logic [N_REQ-1:0]    mem_we,
  input logic [N_REQ-1:0]    sc_done,
  input logic [N_REQ-1:0]    sc_flag
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  for (genvar i = 0; i < N_REQ; i++) begin : g_chk
    logic cond_i, store_i;
    assign cond_i  = req_valid[i] && req_op[2*i +: 2] == 2'd3;
    assign store_i = req_valid[i] && req_op[2*i +: 2] == 2'd2;

    a_r2_flag_only_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
      sc_flag[i] |-> sc_done[i] && cond_i);
    a_r2_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_done[i] && !sc_flag[i]) |-> !mem_we[i]);
    a_r3_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
      store_i |-> mem_we[i]);
    a_r6_back_to_back_cond_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && cond_i && $past(cond_i)) |-> !sc_flag[i]);

    for (genvar j = i + 1; j < N_REQ; j++) begin : g_pair
      a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_flag[i] && sc_flag[j] && req_addr[AW*i +: AW] == req_addr[AW*j +: AW]) |-> 1'b0);
    end
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(.N_REQ(N_REQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .mem_we(mem_we), .sc_done(sc_done), .sc_flag(sc_flag)
);

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [N-1:0]    mem_we, sc_done, sc_flag;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  llsc_monitor #(.N_REQ(N), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .mem_we(mem_we), .sc_done(sc_done), .sc_flag(sc_flag)
  );

  // {valid, op (2b each, 0 load 1 link 2 store 3 cond), addr a3a2a1a0, exp we, exp flag}
  localparam logic [51:0] VEC [NV] = '{
    {4'b0001, 8'h01, 32'h00000010, 4'b0000, 4'b0000}, // R4 link
    {4'b0001, 8'h03, 32'h00000010, 4'b0001, 4'b0001}, // R1 pass
    {4'b0001, 8'h03, 32'h00000010, 4'b0000, 4'b0000}, // R6 consumed
    {4'b0011, 8'h05, 32'h00002020, 4'b0000, 4'b0000}, // two links
    {4'b0011, 8'h0F, 32'h00002020, 4'b0001, 4'b0001}, // R7 lowest wins
    {4'b0100, 8'h10, 32'h00300000, 4'b0000, 4'b0000},
    {4'b1000, 8'h80, 32'h30000000, 4'b1000, 4'b0000}, // R3 store by other
    {4'b0100, 8'h30, 32'h00300000, 4'b0000, 4'b0000}, // R5 cleared
    {4'b0010, 8'h04, 32'h00004000, 4'b0000, 4'b0000},
    {4'b0010, 8'h04, 32'h00004400, 4'b0000, 4'b0000}, // R4 replace
    {4'b0010, 8'h0C, 32'h00004000, 4'b0000, 4'b0000}, // old addr fails
    {4'b1000, 8'h40, 32'h50000000, 4'b0000, 4'b0000},
    {4'b1000, 8'hC0, 32'h51000000, 4'b0000, 4'b0000}, // R6 mismatch fails
    {4'b1000, 8'h40, 32'h50000000, 4'b0000, 4'b0000},
    {4'b0001, 8'h00, 32'h00000050, 4'b0000, 4'b0000}, // R3 load keeps
    {4'b1000, 8'hC0, 32'h50000000, 4'b1000, 4'b1000},
    {4'b0100, 8'h10, 32'h00600000, 4'b0000, 4'b0000},
    {4'b0100, 8'h20, 32'h00600000, 4'b0100, 4'b0000}, // R5 own store
    {4'b0100, 8'h30, 32'h00600000, 4'b0000, 4'b0000},
    {4'b0011, 8'h05, 32'h00007170, 4'b0000, 4'b0000},
    {4'b0011, 8'h0F, 32'h00007170, 4'b0011, 4'b0011}, // distinct words
    {4'b0010, 8'h04, 32'h00008000, 4'b0000, 4'b0000},
    {4'b0011, 8'h0E, 32'h00008080, 4'b0001, 4'b0000}, // R1 same-cycle store
    {4'b1000, 8'h40, 32'h90000000, 4'b0000, 4'b0000},
    {4'b0000, 8'hC0, 32'h90000000, 4'b0000, 4'b0000}, // R9 invalid ignored
    {4'b1000, 8'hC0, 32'h90000000, 4'b1000, 4'b1000}
  };

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] cond_mask(logic [N-1:0] v, logic [2*N-1:0] op);
    for (int i = 0; i < N; i++) cond_mask[i] = v[i] && op[2*i +: 2] == 2'd3;
  endfunction

  task automatic apply(logic [N-1:0] v, logic [2*N-1:0] op, logic [AW*N-1:0] a,
                       logic [N-1:0] we, logic [N-1:0] ok, string tag);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a;
    #2;
    check({tag, " we"}, mem_we, we);
    check({tag, " flag"}, sc_flag, ok);
    check({tag, " done R2"}, sc_done, cond_mask(v, op));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset idle we", mem_we, '0);
    @(negedge clk) rst_n = 1'b1;
    apply(4'b0001, 8'h03, 32'h00000010, 4'b0000, 4'b0000, "R8 cond after reset");

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][51:48], VEC[k][47:40], VEC[k][39:8], VEC[k][7:4], VEC[k][3:0],
            $sformatf("vec %0d R1 R2 R3 R4 R5 R6 R7", k));
    end

    // R8: reset mid-run drops a live reservation
    apply(4'b0001, 8'h01, 32'h000000A0, 4'b0000, 4'b0000, "R8 link");
    @(negedge clk) begin rst_n = 1'b0; req_valid = '0; end
    @(negedge clk) rst_n = 1'b1;
    apply(4'b0001, 8'h03, 32'h000000A0, 4'b0000, 4'b0000, "R8 cleared by reset");

    // R9: link and foreign store to the same word in one cycle keeps link
    apply(4'b0011, 8'h06, 32'h0000B0B0, 4'b0001, 4'b0000, "R9 link with store");
    apply(4'b0010, 8'h0C, 32'h0000B000, 4'b0010, 4'b0010, "R9 link survives");

    @(negedge clk) req_valid = '0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule